// File: doc/BRIEF.md
# Level-Sensed GPIO Port with Interrupt Controller

This block is a general-purpose I/O port of up to 32 pins. Each pin can also raise a level-sensitive interrupt. A small interrupt controller beside the port combines those interrupts into one request line for the host. Software reaches everything through a flat register bus with single-cycle writes and combinational reads. The bus has two banks, chosen by a bank-select input.

**Port bank.** Each pin can drive an output latch or be sampled as an input. Input samples pass through a two-stage synchronizer. After that, each pin's level is compared against a per-pin polarity bit. While a pin's level matches its polarity, the pin's status bit is set on every clock.

**Clearing status.** Software clears a status bit by writing a word with a zero in that bit position. A set that arrives in the same cycle as a clear wins over it, so an interrupt whose level is still present cannot be lost.

**Controller bank.** This bank mirrors the status as a pending word and holds a mask word. The mask resets with every pin blocked. The host request is the registered OR of the pending bits that are not masked.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After reset the direction word is 0 (all inputs), the output latch is 0, the polarity word is all ones, the mask word is all ones, the status word is 0 and `irq_out` is 0.
- R2: Bank 0 (`bus_bank`=0) decodes byte offsets as follows: 0x0 direction, 0x4 data, 0x8 polarity, 0xC status. Bank 1 decodes 0x0 pending (read-only) and 0x8 mask. Any other offset reads 0 and ignores writes.
- R3: A data read returns, for each pin, the synchronized input level if the pin's direction bit is 0, or the output latch bit if the direction bit is 1. A data write updates only the output latch. `pin_out` shows the latch and `pin_oe` shows the direction word.
- R4: A change on `pin_in` appears in data reads after exactly two rising clock edges.
- R5: A status bit sets on an edge when its pin is an input and the synchronized level equals the pin's polarity bit (1 = active high, 0 = active low). A pin whose direction bit is 1 never sets status. No status bit sets without this condition.
- R6: A write to status clears every bit whose written value is 0 and leaves every bit whose written value is 1 unchanged.
- R7: Sensing is by level only: a cleared bit sets again on the next edge at which its level condition holds.
- R8: When a clear and a set condition for the same bit fall on the same edge, the bit ends up set.
- R9: The pending word in bank 1 always reads equal to the status word.
- R10: `irq_out` is a register that on each edge takes the OR of (status AND NOT mask). It stays 0 while every mask bit is 1. A mask bit of 1 blocks its pin.
- R11: The mask word reads back what was written, and it changes only on writes to bank 1, offset 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_bank | input | 1 | Bank select: 0 port bank, 1 controller bank |
| bus_addr | input | 4 | Byte offset within the bank |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Combinational read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enable per pin (direction word) |
| irq_out | output | 1 | Combined interrupt request to the host |

## Verification
A corrupted synchronizer stage or polarity bit shows up as a data or status read that differs from the pin pattern. The bench checks this at the exact edge count: two edges for data reads, three for status.

A clear that wins over a set, or a clear that reaches the wrong bits, shows up on the status readback one cycle after the acknowledge write. A wrong mask or a missing output register moves `irq_out` one cycle early or late, or makes it fire while masked. The bench samples `irq_out` both in the cycle after a mask or status change and in the cycle after that, so either fault is caught.

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_bank,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_out
);
  localparam logic [3:0] OFS_DIR  = 4'h0;
  localparam logic [3:0] OFS_DATA = 4'h4;
  localparam logic [3:0] OFS_POL  = 4'h8;
  localparam logic [3:0] OFS_STAT = 4'hC;
  localparam logic [3:0] OFS_PEND = 4'h0;
  localparam logic [3:0] OFS_MASK = 4'h8;

  logic [NPINS-1:0] dir_q, out_q, pol_q, stat_q, mask_q;
  logic [NPINS-1:0] meta_q, sync_q;
  logic [NPINS-1:0] set_vec;
  logic             irq_q;

  wire port_wr = bus_wr && !bus_bank;
  wire ctl_wr  = bus_wr &&  bus_bank;
  wire wr_dir  = port_wr && (bus_addr == OFS_DIR);
  wire wr_data = port_wr && (bus_addr == OFS_DATA);
  wire wr_pol  = port_wr && (bus_addr == OFS_POL);
  wire wr_stat = port_wr && (bus_addr == OFS_STAT);
  wire wr_mask = ctl_wr  && (bus_addr == OFS_MASK);

  assign set_vec = ~(sync_q ^ pol_q) & ~dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      pol_q  <= '1;
      mask_q <= '1;
    end else begin
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_data) out_q  <= bus_wdata;
      if (wr_pol)  pol_q  <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (wr_stat) stat_q <= (stat_q & bus_wdata) | set_vec;
    else stat_q <= stat_q | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else irq_q <= |(stat_q & ~mask_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_bank) begin
      case (bus_addr)
        OFS_DIR:  bus_rdata = dir_q;
        OFS_DATA: bus_rdata = (sync_q & ~dir_q) | (out_q & dir_q);
        OFS_POL:  bus_rdata = pol_q;
        OFS_STAT: bus_rdata = stat_q;
        default:  bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        OFS_PEND: bus_rdata = stat_q;
        OFS_MASK: bus_rdata = mask_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_out = irq_q;

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !irq_out);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((($past(set_vec)) & ~stat_q) == '0));

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(set_vec)) == '0));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & ~$past(bus_wdata) & ~$past(set_vec)) == '0));

  p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: tb/gpio_lvl_irq_bench.sv
module gpio_lvl_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_bank = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  gpio_lvl_irq #(.NPINS(32)) u_gpio_lvl_irq (
    .clk(clk), .rst_n(rst_n), .bus_bank(bus_bank), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // {bank, offset, write data, expected readback at same offset}
  localparam logic [68:0] VEC [7] = '{
    {1'b0, 4'h0, 32'hFFFF0000, 32'hFFFF0000},
    {1'b0, 4'h8, 32'h00FF00FF, 32'h00FF00FF},
    {1'b1, 4'h8, 32'h12345678, 32'h12345678},
    {1'b0, 4'h4, 32'hA5A5A5A5, 32'hA5A50000},
    {1'b1, 4'h4, 32'hFFFFFFFF, 32'h00000000},
    {1'b0, 4'h0, 32'h00000000, 32'h00000000},
    {1'b0, 4'h4, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_bank = b; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic b, input logic [3:0] a, output logic [31:0] v);
    bus_bank = b; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin_in = '0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R2 R3 R11: register table walk
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][68], VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][68], VEC[i][67:64], v);
      chk($sformatf("R2 table entry %0d", i), v, VEC[i][31:0]);
    end

    do_reset();
    // R1 reset state
    rd(1'b0, 4'h0, v); chk("R1 direction", v, 32'h0);
    rd(1'b0, 4'h8, v); chk("R1 polarity", v, 32'hFFFFFFFF);
    rd(1'b1, 4'h8, v); chk("R1 mask", v, 32'hFFFFFFFF);
    rd(1'b0, 4'hC, v); chk("R1 status", v, 32'h0);
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);

    // R4 synchronizer latency, R5 status set, R9 pending
    pin_in[3] = 1'b1;
    edges(1); rd(1'b0, 4'h4, v); chk("R4 data after one edge", v, 32'h0);
    edges(1); rd(1'b0, 4'h4, v); chk("R4 data after two edges", v, 32'h8);
    edges(1); rd(1'b0, 4'hC, v); chk("R5 status active high", v, 32'h8);
    rd(1'b1, 4'h0, v); chk("R9 pending mirrors status", v, 32'h8);
    chk("R10 masked irq quiet", {31'b0, irq_out}, 32'h0);

    // R10 unmask, registered output
    wr(1'b1, 4'h8, 32'hFFFFFFF7);
    chk("R10 irq one cycle after unmask", {31'b0, irq_out}, 32'h0);
    edges(1);
    chk("R10 irq after unmask", {31'b0, irq_out}, 32'h1);
    rd(1'b1, 4'h8, v); chk("R11 mask readback", v, 32'hFFFFFFF7);

    // R8 ack while level persists
    wr(1'b0, 4'hC, 32'hFFFFFFF7);
    rd(1'b0, 4'hC, v); chk("R8 set wins over clear", v, 32'h8);

    // R6 clear after level drops, R10 irq falls one cycle later
    pin_in[3] = 1'b0;
    edges(2);
    wr(1'b0, 4'hC, 32'hFFFFFFF7);
    rd(1'b0, 4'hC, v); chk("R6 cleared by zero bit", v, 32'h0);
    chk("R10 irq still registered", {31'b0, irq_out}, 32'h1);
    edges(1);
    chk("R10 irq dropped", {31'b0, irq_out}, 32'h0);

    // R6 selective clear
    pin_in[3] = 1'b1; pin_in[5] = 1'b1;
    edges(3); rd(1'b0, 4'hC, v); chk("R5 two pins set", v, 32'h28);
    pin_in[3] = 1'b0; pin_in[5] = 1'b0;
    edges(2);
    wr(1'b0, 4'hC, 32'hFFFFFFF7);
    rd(1'b0, 4'hC, v); chk("R6 only zero bit cleared", v, 32'h20);
    wr(1'b0, 4'hC, 32'hFFFFFFDF);
    rd(1'b0, 4'hC, v); chk("R6 second clear", v, 32'h0);

    // R7 re-assert on returning level
    pin_in[5] = 1'b1;
    edges(3); rd(1'b0, 4'hC, v); chk("R7 level sets again", v, 32'h20);
    pin_in[5] = 1'b0;
    edges(2);
    wr(1'b0, 4'hC, 32'h0);

    // R5 active-low polarity
    wr(1'b0, 4'h8, 32'hFFFFFEFF);
    edges(1); rd(1'b0, 4'hC, v); chk("R5 active low sets", v, 32'h100);

    // R5 output pin never sets, R3 data read of output pin
    wr(1'b0, 4'h0, 32'h00000200);
    wr(1'b0, 4'h4, 32'h00000000);
    pin_in[9] = 1'b1;
    edges(3);
    rd(1'b0, 4'hC, v); chk("R5 output pin ignored", v & 32'h200, 32'h0);
    rd(1'b0, 4'h4, v); chk("R3 output pin reads latch", v & 32'h200, 32'h0);
    chk("R3 pin_oe", pin_oe, 32'h200);
    wr(1'b0, 4'h4, 32'h00000200);
    chk("R3 pin_out", pin_out, 32'h200);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule